// File: doc/BRIEF.md
# HDB3 Line Encoder

This block turns a serial binary stream into the two-rail form used to drive an E1 line interface. It emits one symbol for each input bit that arrives with the bit enable. A symbol is a pulse on the positive rail, a pulse on the negative rail, or no pulse. Ones become marks whose polarity alternates. A zero becomes no pulse. A run of four zeros is replaced by a substitution pattern that ends in a deliberate polarity violation. This keeps the line rich in transitions for clock recovery and keeps it free of any DC level.

The encoder holds the last four bits in a short window. A zero run is therefore recognised before its first zero reaches the line. The run's leading symbol is then chosen as a balancing pulse or a blank, depending on how many marks have gone out since the previous violation. The cost of this look-ahead is a fixed delay of four bit enables. Clock cycles without the enable do not advance the coder, so the enable can gate the system clock down to the line rate.

Top module: `hdb3_line_encoder`

## Requirements
- R1: An input one that is not part of a substitution is sent as a mark whose polarity is opposite to the previous pulse on the line. An input zero outside a substitution is sent with both rails low.
- R2: The symbol for the input bit taken at enable k appears on the rails after enable k+4. After reset, the first four enables produce no pulse.
- R3: The line never carries more than three no-pulse symbols in a row, counted from the first symbol that belongs to input data.
- R4: When an odd number of marks has been sent since the last violation, four input zeros go out as blank, blank, blank, V. V has the same polarity as the pulse before it.
- R5: When an even number of marks has been sent since the last violation (this includes none), four input zeros go out as B, blank, blank, V. B has the polarity opposite to the pulse before it, and V repeats B's polarity.
- R6: Two successive violations never have the same polarity.
- R7: During and right after reset, both rails are low, the last-pulse polarity is negative and the mark count is even. The first mark after reset is therefore positive.
- R8: The positive rail and the negative rail are never high in the same cycle.
- R9: In cycles without the bit enable, both rails hold their value and the coder state does not move. Gaps between enables leave the coded sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit enable: one input bit taken and one symbol produced |
| bit_in | input | 1 | Serial data bit |
| line_pos | output | 1 | Positive-pulse rail |
| line_neg | output | 1 | Negative-pulse rail |

## Verification
The assertions check on every cycle that the two rails are exclusive and that the rails hold when the enable is absent. They also check that each data one produces a pulse, that a violation always repeats the polarity of the pulse before it, and that successive violations alternate. Only the directed scenarios can show that the exact symbol sequence matches an independent reference coder: the choice between B00V and 000V, the four-enable latency with its blank prologue, and the bound on runs of blanks. These scenarios cover odd-parity runs, even-parity runs, all-zero input and mixed data with enable gaps.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;
    localparam int RUN_LEN = 4;

    typedef enum logic [1:0] {
        SYM_DATA = 2'd0,
        SYM_HEAD = 2'd1,
        SYM_VIOL = 2'd2
    } sym_tag_e;

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } pol_e;

    typedef struct packed {
        logic     valid;
        logic     bit_v;
        sym_tag_e tag;
    } slot_t;
endpackage

// File: rtl/hdb3_window.sv
module hdb3_window
    import hdb3_pkg::*;
#(
    parameter int DEPTH = RUN_LEN
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  bit_in,
    output slot_t oldest
);
    typedef struct packed {
        slot_t [DEPTH-1:0] line;
    } win_t;

    win_t st_d, st_q;
    logic run_hit;

    always_comb begin
        logic zeros;
        zeros = !bit_in;
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (!(st_q.line[i].valid && !st_q.line[i].bit_v &&
                  st_q.line[i].tag != SYM_VIOL))
                zeros = 1'b0;
        end
        run_hit = zeros;

        st_d = st_q;
        if (en) begin
            for (int i = DEPTH - 1; i > 0; i--)
                st_d.line[i] = st_q.line[i-1];
            st_d.line[0].valid = 1'b1;
            st_d.line[0].bit_v = bit_in;
            st_d.line[0].tag   = run_hit ? SYM_VIOL : SYM_DATA;
            if (run_hit)
                st_d.line[DEPTH-1].tag = SYM_HEAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oldest = st_q.line[DEPTH-1];

    // A head is always followed by its violation three shifts later,
    // so a head at the output stage means a violation tag is in flight
    assert_head_has_viol_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (oldest.valid && oldest.tag == SYM_HEAD) |-> (st_q.line[0].tag == SYM_VIOL));
endmodule

// File: rtl/hdb3_symbol_gen.sv
module hdb3_symbol_gen
    import hdb3_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  slot_t slot,
    output logic  rail_pos,
    output logic  rail_neg
);
    typedef struct packed {
        pol_e last;
        logic odd;
        logic pos;
        logic neg;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        pol_e flip;
        flip = (st_q.last == POL_POS) ? POL_NEG : POL_POS;
        st_d = st_q;
        if (en) begin
            st_d.pos = 1'b0;
            st_d.neg = 1'b0;
            if (slot.valid) begin
                if (slot.bit_v) begin
                    st_d.pos  = (flip == POL_POS);
                    st_d.neg  = (flip == POL_NEG);
                    st_d.last = flip;
                    st_d.odd  = !st_q.odd;
                end else if (slot.tag == SYM_HEAD) begin
                    if (!st_q.odd) begin
                        st_d.pos  = (flip == POL_POS);
                        st_d.neg  = (flip == POL_NEG);
                        st_d.last = flip;
                    end
                end else if (slot.tag == SYM_VIOL) begin
                    st_d.pos = (st_q.last == POL_POS);
                    st_d.neg = (st_q.last == POL_NEG);
                    st_d.odd = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{last: POL_NEG, odd: 1'b0, pos: 1'b0, neg: 1'b0};
        else        st_q <= st_d;
    end

    assign rail_pos = st_q.pos;
    assign rail_neg = st_q.neg;

    // checker state: polarity of the previous violation
    logic chk_seen_q;
    pol_e chk_vpol_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_seen_q <= 1'b0;
            chk_vpol_q <= POL_NEG;
        end else if (en && slot.valid && slot.tag == SYM_VIOL) begin
            chk_seen_q <= 1'b1;
            chk_vpol_q <= st_q.last;
        end
    end

    assert_viol_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && slot.valid && slot.tag == SYM_VIOL && chk_seen_q) |-> (st_q.last != chk_vpol_q));

    assert_viol_repeats_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && slot.valid && slot.tag == SYM_VIOL) |=>
        (rail_pos == ($past(st_q.last) == POL_POS)) && (rail_pos != rail_neg));
endmodule

// File: rtl/hdb3_line_encoder.sv
module hdb3_line_encoder
    import hdb3_pkg::*;
#(
    parameter int WINDOW = RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic line_pos,
    output logic line_neg
);
    slot_t out_slot;

    hdb3_window #(.DEPTH(WINDOW)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (bit_en),
        .bit_in (bit_in),
        .oldest (out_slot)
    );

    hdb3_symbol_gen u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (bit_en),
        .slot     (out_slot),
        .rail_pos (line_pos),
        .rail_neg (line_neg)
    );

    assert_rails_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_pos && line_neg));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable({line_pos, line_neg}));

    assert_mark_sent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && out_slot.valid && out_slot.bit_v) |=> (line_pos || line_neg));

    assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!line_pos && !line_neg));
endmodule

// File: tb/hdb3_line_encoder_test.sv
`timescale 1ns/1ps
module hdb3_line_encoder_test;
    localparam int MAXN = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic line_pos, line_neg;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int stim [0:MAXN-1];
    int expv [0:MAXN-1];
    int obs  [0:MAXN-1];

    always #4 clk = ~clk;

    hdb3_line_encoder uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .line_pos(line_pos), .line_neg(line_neg)
    );

    function automatic int rail_val();
        return line_pos ? (line_neg ? 2 : 1) : (line_neg ? -1 : 0);
    endfunction

    task automatic check(string req, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // independent sequential reference coder
    task automatic build_ref(int n);
        int last = -1;
        int odd = 0;
        int zc = 0;
        for (int i = 0; i < n; i++) begin
            if (stim[i] != 0) begin
                zc = 0; last = -last; expv[i] = last; odd ^= 1;
            end else begin
                expv[i] = 0; zc++;
                if (zc == 4) begin
                    if (odd == 0) begin
                        last = -last; expv[i-3] = last;
                    end
                    expv[i] = last; odd = 0; zc = 0;
                end
            end
        end
    endtask

    task automatic do_reset();
        bit_en = 1'b0; bit_in = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_seq(string req, int n, int gap);
        int prev;
        int vprev;
        int run;
        int maxrun;
        int alt_bad;
        build_ref(n);
        do_reset();
        check("R7 rails low after reset", rail_val(), 0);
        for (int k = 0; k < n; k++) begin
            bit_en = 1'b1; bit_in = stim[k][0];
            @(negedge clk);
            bit_en = 1'b0;
            obs[k] = rail_val();
            if (k < 4) check({req, " R2 prologue"}, obs[k], 0);
            else       check(req, obs[k], expv[k-4]);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check("R9 hold without enable", rail_val(), obs[k]);
            end
        end
        // line properties over data symbols
        prev = 0; vprev = 0; run = 0; maxrun = 0; alt_bad = 0;
        for (int k = 4; k < n; k++) begin
            if (obs[k] == 0) begin
                run++;
                if (run > maxrun) maxrun = run;
            end else begin
                run = 0;
                if (prev != 0 && obs[k] == prev) begin
                    if (vprev != 0 && vprev == obs[k]) alt_bad++;
                    vprev = obs[k];
                end
                prev = obs[k];
            end
        end
        check("R3 blank run bound", (maxrun <= 3) ? 1 : 0, 1);
        check("R6 violation alternation", alt_bad, 0);
    endtask

    task automatic t_ones();
        for (int i = 0; i < 24; i++) stim[i] = 1;
        run_seq("R1 alternating marks", 24, 0);
        check("R7 first mark positive", obs[4], 1);
    endtask

    task automatic t_odd_runs();
        for (int i = 0; i < 30; i++) stim[i] = ((i % 5) == 0) ? 1 : 0;
        run_seq("R4 odd parity 000V", 30, 0);
        // 1 -> +, then 000V with V=+
        check("R4 V repeats previous mark", obs[8], 1);
        check("R4 leading blank", obs[5], 0);
    endtask

    task automatic t_even_runs();
        for (int i = 0; i < 30; i++) stim[i] = ((i % 6) < 2) ? 1 : 0;
        run_seq("R5 even parity B00V", 30, 0);
        // + - then B=+, V=+
        check("R5 B opposite previous", obs[6], 1);
        check("R5 V repeats B", obs[9], 1);
    endtask

    task automatic t_all_zero();
        for (int i = 0; i < 40; i++) stim[i] = 0;
        run_seq("R5 all zeros", 40, 0);
        check("R5 first B positive", obs[4], 1);
        check("R6 second run opposite", obs[8], -1);
    endtask

    task automatic t_mixed_gaps();
        logic [7:0] lf = 8'hA5;
        for (int i = 0; i < 80; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            stim[i] = (lf[0] && lf[1] && (i % 9 != 3)) ? 1 : 0;
        end
        run_seq("R9 mixed data with gaps", 80, 2);
        run_seq("R1 mixed data no gaps", 80, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R2 watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_ones();
        t_odd_runs();
        t_even_runs();
        t_all_zero();
        t_mixed_gaps();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule